// File: doc/BRIEF.md
# Cartridge SRAM Access Sequencer

This block sits on the host side of an 8-bit I/O bus, in front of a battery-backed SRAM cartridge that can only be reached through four I/O ports. The four ports are a low-address latch, a high-address and enable latch, a bidirectional data port and a direction (mode) register. A client hands the block one request at a time, with a 12-bit byte address, a data byte and a read/write flag. The block turns that request into the ordered series of I/O write and read cycles the cartridge needs. The order is fixed so that address and data lines are settled before the chip-enable bit is raised, and so that chip enable is dropped again right after each access. For a read, the data port is switched to input before any output enable is raised.

The block remembers which direction it last programmed into the mode register. It writes the mode register only on the first request after reset or when the request type differs from the previous one. A run of reads or a run of writes therefore costs one bus cycle less per access after the first.

The controller is an enumerated machine with three states:
- `S_IDLE`: waiting, and `req_ready` is high.
- `S_STROBE`: one bus cycle's strobe is held for `STROBE_CLKS` clocks.
- `S_GAP`: the single idle clock that follows every bus cycle.

Its transitions are:
- `S_IDLE` to `S_STROBE` when a request is accepted.
- `S_STROBE` to `S_GAP` on the last strobe clock.
- `S_GAP` to `S_STROBE` when more steps remain.
- `S_GAP` to `S_IDLE` after the closing step, with `rsp_done` raised in that gap clock.

The steps within a request are:
- `STEP_MODE`: write the mode register.
- `STEP_DATA`: write the data port.
- `STEP_ALO`: write the low address byte.
- `STEP_ARM`: raise the enables.
- `STEP_SAMPLE`: read the data port.
- `STEP_DISARM`: drop chip enable.

Top module: `cart_seq`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. While busy, a held `req_valid` starts nothing, and no strobe is active while idle.
- R2: A read issues, in order:
  - a write of the low address byte to port BASE+0;
  - a write of C0h OR the high address nibble to port BASE+1 (bit 7 is output enable, bit 6 is chip enable);
  - a read strobe on port BASE+2;
  - a write of 80h OR the high nibble to BASE+1 (with the default `PARK_WITH_OE`=1).
- R3: A write issues, in order:
  - the data byte to BASE+2;
  - the low address byte to BASE+0;
  - 40h OR the high nibble to BASE+1;
  - 00h OR the high nibble to BASE+1.
- R4: The first request after reset, and any request whose type differs from the previous request, is preceded by a write to BASE+3 of 89h (read) or 80h (write). A request of the same type as its predecessor has no such cycle.
- R5: Every bus cycle holds exactly one of `io_wr`/`io_rd` for `STROBE_CLKS` clocks and is followed by one clock with both strobes low. `io_addr` and `io_wdata` are zero whenever no write strobe (for `io_wdata`) or no strobe at all (for `io_addr`) is active.
- R6: `rsp_done` is high for one clock, in the idle clock after the last bus cycle, and `req_ready` rises on the next clock.
- R7: `rsp_rdata` takes the `io_rdata` value present on the last clock of the read strobe. It keeps that value through later write requests until the next read samples again.
- R8: An enable write with bits 7:6 = 11 is only issued after 89h was the last mode write, and one with bits 7:6 = 01 only after 80h was.
- R9: During and right after reset, `req_ready` is 1, `io_wr`, `io_rd` and `rsp_done` are 0, and `rsp_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 12 | Cartridge byte address |
| req_wdata | input | 8 | Byte to store (write requests) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last byte read from the cartridge |
| io_addr | output | 8 | I/O port number of the current bus cycle |
| io_wdata | output | 8 | Byte driven on an I/O write cycle |
| io_wr | output | 1 | I/O write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_rdata | input | 8 | Byte returned on an I/O read cycle |

## Verification
The checker watches three things on every clock:
- the bus rules that protect the cartridge: an enable write may never disagree with the last mode word, strobes are never both high, and read strobes only target the data port;
- the handshake: no re-acceptance while busy, and a single-clock done that never coincides with ready;
- read data, which changes only while busy.

Only the bench scenarios can show that the step order is exact, that the mode cycle is skipped on same-type runs and issued on type changes, that the timing is right, and that bytes written through the bus come back on a later read at address boundaries.

// File: rtl/cart_seq_pkg.sv
package cart_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STROBE,
        S_GAP
    } fsm_t;

    typedef enum logic [2:0] {
        STEP_MODE,
        STEP_DATA,
        STEP_ALO,
        STEP_ARM,
        STEP_SAMPLE,
        STEP_DISARM
    } step_t;

    typedef enum logic [1:0] {
        DIR_UNSET,
        DIR_IN,
        DIR_OUT
    } dir_t;

    // port offsets from the base I/O address
    localparam logic [7:0] OFS_ADDR_LO = 8'd0;
    localparam logic [7:0] OFS_ENABLE  = 8'd1;
    localparam logic [7:0] OFS_DATA    = 8'd2;
    localparam logic [7:0] OFS_MODE    = 8'd3;

    // mode words and enable-latch bit positions
    localparam logic [7:0] MODE_WORD_IN  = 8'h89;
    localparam logic [7:0] MODE_WORD_OUT = 8'h80;
    localparam int         BIT_CHIP_EN   = 6;
    localparam int         BIT_OUT_EN    = 7;

    function automatic step_t first_step(input logic need_mode, input logic is_write);
        if (need_mode)
            return STEP_MODE;
        return is_write ? STEP_DATA : STEP_ALO;
    endfunction

    function automatic step_t step_after(input step_t s, input logic is_write);
        step_t n;
        case (s)
            STEP_MODE:   n = is_write ? STEP_DATA : STEP_ALO;
            STEP_DATA:   n = STEP_ALO;
            STEP_ALO:    n = STEP_ARM;
            STEP_ARM:    n = is_write ? STEP_DISARM : STEP_SAMPLE;
            STEP_SAMPLE: n = STEP_DISARM;
            default:     n = STEP_DISARM;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cart_seq_step_decode.sv
module cart_seq_step_decode
    import cart_seq_pkg::*;
#(
    parameter logic [7:0] BASE_PORT    = 8'hB0,
    parameter int         ADDR_W       = 12,
    parameter bit         PARK_WITH_OE = 1'b1
) (
    input  step_t             step,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        cyc_port,
    output logic [7:0]        cyc_data,
    output logic              cyc_read
);

    localparam logic [7:0] ENA_CE    = 8'(1) << BIT_CHIP_EN;
    localparam logic [7:0] ENA_OE    = 8'(1) << BIT_OUT_EN;
    localparam logic [7:0] ARM_READ  = ENA_CE | ENA_OE;
    localparam logic [7:0] ARM_WRITE = ENA_CE;
    localparam logic [7:0] PARK_READ = PARK_WITH_OE ? ENA_OE : 8'h00;

    logic [7:0] hi_field;

    always_comb begin
        hi_field = 8'(addr[ADDR_W-1:8]);
    end

    always_comb begin
        cyc_port = BASE_PORT;
        cyc_data = 8'h00;
        cyc_read = 1'b0;
        unique case (step)
            STEP_MODE: begin
                cyc_port = BASE_PORT + OFS_MODE;
                cyc_data = is_write ? MODE_WORD_OUT : MODE_WORD_IN;
            end
            STEP_DATA: begin
                cyc_port = BASE_PORT + OFS_DATA;
                cyc_data = wdata;
            end
            STEP_ALO: begin
                cyc_port = BASE_PORT + OFS_ADDR_LO;
                cyc_data = addr[7:0];
            end
            STEP_ARM: begin
                cyc_port = BASE_PORT + OFS_ENABLE;
                cyc_data = (is_write ? ARM_WRITE : ARM_READ) | hi_field;
            end
            STEP_SAMPLE: begin
                cyc_port = BASE_PORT + OFS_DATA;
                cyc_read = 1'b1;
            end
            STEP_DISARM: begin
                cyc_port = BASE_PORT + OFS_ENABLE;
                cyc_data = (is_write ? 8'h00 : PARK_READ) | hi_field;
            end
            default: begin
                cyc_port = BASE_PORT;
            end
        endcase
    end

endmodule

// File: rtl/cart_seq_strobe_timer.sv
module cart_seq_strobe_timer #(
    parameter int STROBE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic at_last
);

    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        at_last = active && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!active || at_last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/cart_seq_dir_track.sv
module cart_seq_dir_track
    import cart_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  dir_t want,
    output dir_t cur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur <= DIR_UNSET;
        else if (upd)
            cur <= want;
    end

endmodule

// File: rtl/cart_seq.sv
module cart_seq
    import cart_seq_pkg::*;
#(
    parameter logic [7:0] BASE_PORT    = 8'hB0,
    parameter int         ADDR_W       = 12,
    parameter int         STROBE_CLKS  = 2,
    parameter bit         PARK_WITH_OE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_done,
    output logic [7:0]        rsp_rdata,
    output logic [7:0]        io_addr,
    output logic [7:0]        io_wdata,
    output logic              io_wr,
    output logic              io_rd,
    input  logic [7:0]        io_rdata
);

    fsm_t              state_q, state_d;
    step_t             step_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;

    logic              accept;
    logic              need_mode;
    logic              strobe_last;
    logic              final_step;
    dir_t              dir_cur;
    dir_t              dir_want;
    logic [7:0]        cyc_port;
    logic [7:0]        cyc_data;
    logic              cyc_read;

    always_comb begin
        accept     = req_valid && (state_q == S_IDLE);
        dir_want   = req_write ? DIR_OUT : DIR_IN;
        need_mode  = (dir_cur != dir_want);
        final_step = (step_q == STEP_DISARM);
    end

    cart_seq_dir_track u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (accept),
        .want  (dir_want),
        .cur   (dir_cur)
    );

    cart_seq_strobe_timer #(
        .STROBE_CLKS (STROBE_CLKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == S_STROBE),
        .at_last (strobe_last)
    );

    cart_seq_step_decode #(
        .BASE_PORT    (BASE_PORT),
        .ADDR_W       (ADDR_W),
        .PARK_WITH_OE (PARK_WITH_OE)
    ) u_decode (
        .step     (step_q),
        .is_write (wr_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .cyc_port (cyc_port),
        .cyc_data (cyc_data),
        .cyc_read (cyc_read)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_STROBE;
            S_STROBE: if (strobe_last) state_d = S_GAP;
            S_GAP:    state_d = final_step ? S_IDLE : S_STROBE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // request latch, step pointer and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= STEP_MODE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                step_q  <= first_step(need_mode, req_write);
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end else if (state_q == S_GAP && !final_step) begin
                step_q <= step_after(step_q, wr_q);
            end
            if (state_q == S_STROBE && strobe_last && step_q == STEP_SAMPLE)
                rdata_q <= io_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_done  = (state_q == S_GAP) && final_step;
        rsp_rdata = rdata_q;
        io_wr     = (state_q == S_STROBE) && !cyc_read;
        io_rd     = (state_q == S_STROBE) && cyc_read;
        io_addr   = (state_q == S_STROBE) ? cyc_port : 8'h00;
        io_wdata  = io_wr ? cyc_data : 8'h00;
    end

endmodule

// File: rtl/cart_seq_checker.sv
module cart_seq_checker #(
    parameter logic [7:0] BASE_PORT = 8'hB0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_done,
    input logic [7:0] rsp_rdata,
    input logic [7:0] io_addr,
    input logic [7:0] io_wdata,
    input logic       io_wr,
    input logic       io_rd
);

    logic [7:0] last_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_mode_q <= 8'h00;
        else if (io_wr && io_addr == BASE_PORT + 8'd3)
            last_mode_q <= io_wdata;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!io_wr && !io_rd));

    assert_no_reaccept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_read_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |-> (io_addr == BASE_PORT + 8'd2));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> !req_ready);

    assert_oe_after_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == BASE_PORT + 8'd1 && io_wdata[7:6] == 2'b11)
            |-> (last_mode_q == 8'h89));

    assert_we_after_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == BASE_PORT + 8'd1 && io_wdata[7:6] == 2'b01)
            |-> (last_mode_q == 8'h80));

endmodule

bind cart_seq cart_seq_checker #(
    .BASE_PORT (BASE_PORT)
) u_cart_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_wr     (io_wr),
    .io_rd     (io_rd)
);

// File: tb/cart_seq_bench.sv
`timescale 1ns/1ps
module cart_seq_bench;

    localparam int STROBE = 2;
    localparam logic [7:0] BASE = 8'hB0;

    typedef struct {
        bit         wr;
        bit         rd;
        bit [7:0]   a;
        bit [7:0]   d;
        bit         done;
        bit         upd;
        bit [7:0]   rv;
        string      tag;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [7:0]  io_addr;
    logic [7:0]  io_wdata;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_rdata;

    int vectors = 0;
    int misses = 0;
    int cycles = 0;

    rec_t     q[$];
    bit       cool = 0;
    bit       acc_flag = 0;
    int       dir_model = 0;   // 0 unset, 1 read, 2 write
    bit [7:0] model_rdata = 8'h00;
    bit [7:0] shadow [4096];

    // cartridge model registers
    logic [7:0] c_lo = 8'h00, c_ena = 8'h00, c_dat = 8'h00, c_mode = 8'h00;
    logic [7:0] c_mem [4096];

    always #5 clk = ~clk;

    cart_seq #(
        .BASE_PORT   (BASE),
        .ADDR_W      (12),
        .STROBE_CLKS (STROBE)
    ) u_cart_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata)
    );

    // port-mapped SRAM cartridge
    assign io_rdata = (c_mode == 8'h89 && c_ena[7:6] == 2'b11) ? c_mem[{c_ena[3:0], c_lo}] : 8'hFF;

    always @(posedge clk) begin
        if (io_wr) begin
            case (io_addr)
                BASE + 8'd0: c_lo   <= io_wdata;
                BASE + 8'd1: c_ena  <= io_wdata;
                BASE + 8'd2: c_dat  <= io_wdata;
                BASE + 8'd3: c_mode <= io_wdata;
                default: ;
            endcase
        end
        if (c_mode == 8'h80 && c_ena[6] && !c_ena[7])
            c_mem[{c_ena[3:0], c_lo}] <= c_dat;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic add_cycle(input bit rd, input bit [7:0] a, input bit [7:0] d,
                             input bit upd, input bit [7:0] rv, input bit last, input string tag);
        rec_t r;
        for (int k = 0; k < STROBE; k++) begin
            r.wr = !rd; r.rd = rd; r.a = a; r.d = rd ? 8'h00 : d;
            r.done = 0; r.upd = 0; r.rv = 0; r.tag = tag;
            q.push_back(r);
        end
        r.wr = 0; r.rd = 0; r.a = 0; r.d = 0;
        r.done = last; r.upd = upd; r.rv = rv; r.tag = last ? "R6" : "R5";
        q.push_back(r);
    endtask

    // expected bus activity of one request
    task automatic plan(input bit w, input bit [11:0] ad, input bit [7:0] dt);
        bit [7:0] hi;
        hi = {4'h0, ad[11:8]};
        if (dir_model != (w ? 2 : 1)) begin
            add_cycle(0, BASE + 8'd3, w ? 8'h80 : 8'h89, 0, 0, 0, "R4");
            dir_model = w ? 2 : 1;
        end
        if (w) begin
            add_cycle(0, BASE + 8'd2, dt, 0, 0, 0, "R3");
            add_cycle(0, BASE + 8'd0, ad[7:0], 0, 0, 0, "R3");
            add_cycle(0, BASE + 8'd1, 8'h40 | hi, 0, 0, 0, "R3");
            add_cycle(0, BASE + 8'd1, hi, 0, 0, 1, "R3");
            shadow[ad] = dt;
        end else begin
            add_cycle(0, BASE + 8'd0, ad[7:0], 0, 0, 0, "R2");
            add_cycle(0, BASE + 8'd1, 8'hC0 | hi, 0, 0, 0, "R2");
            add_cycle(1, BASE + 8'd2, 8'h00, 1, shadow[ad], 0, "R7");
            add_cycle(0, BASE + 8'd1, 8'h80 | hi, 0, 0, 1, "R2");
        end
    endtask

    // acceptance model
    always @(posedge clk) begin
        acc_flag = 0;
        cycles++;
        if (rst_n) begin
            if (req_valid && q.size() == 0 && !cool) begin
                plan(req_write, req_addr, req_wdata);
                acc_flag = 1;
            end
            cool = 0;
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (q.size() > 0) begin
                rec_t r;
                r = q.pop_front();
                if (r.upd) model_rdata = r.rv;
                check(r.tag, "io_wr", io_wr, r.wr);
                check(r.tag, "io_rd", io_rd, r.rd);
                check(r.tag, "io_addr", io_addr, r.a);
                check(r.tag, "io_wdata", io_wdata, r.d);
                check("R6", "rsp_done", rsp_done, r.done);
                check("R1", "req_ready busy", req_ready, 0);
                check("R7", "rsp_rdata", rsp_rdata, model_rdata);
                if (r.done) cool = 1;
            end else begin
                check("R1", "req_ready idle", req_ready, 1);
                check("R1", "io_wr idle", io_wr, 0);
                check("R1", "io_rd idle", io_rd, 0);
                check("R5", "io_addr idle", io_addr, 0);
                check("R5", "io_wdata idle", io_wdata, 0);
                check("R6", "rsp_done idle", rsp_done, 0);
                check("R7", "rsp_rdata idle", rsp_rdata, model_rdata);
            end
        end
    end

    task automatic do_req(input bit w, input bit [11:0] ad, input bit [7:0] dt);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = ad; req_wdata = dt;
        forever begin
            @(posedge clk);
            #1;
            if (acc_flag) break;
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || cool) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // watchdog
    initial begin
        #1500000;
        misses++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            shadow[i] = 8'((i * 37 + 11) ^ (i >> 4));
            c_mem[i]  = 8'((i * 37 + 11) ^ (i >> 4));
        end
        repeat (4) @(negedge clk);
        // R9: reset state
        vectors++;
        check("R9", "req_ready in reset", req_ready, 1);
        check("R9", "io_wr in reset", io_wr, 0);
        check("R9", "io_rd in reset", io_rd, 0);
        check("R9", "rsp_done in reset", rsp_done, 0);
        check("R9", "rsp_rdata in reset", rsp_rdata, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3/R4: first write after reset carries a mode cycle
        do_req(1, 12'h123, 8'h5A);
        // R2/R4: type change back to read
        do_req(0, 12'h123, 8'h00);
        // R4: reads in a row skip the mode cycle; R2 boundary addresses
        do_req(0, 12'h000, 8'h00);
        do_req(0, 12'hFFF, 8'h00);
        // R3/R4: writes in a row, R7 read data held meanwhile
        do_req(1, 12'hFFF, 8'hA5);
        do_req(1, 12'h800, 8'h3C);
        do_req(1, 12'h0FF, 8'hC3);
        wait_idle();
        // R7: stored bytes come back
        do_req(0, 12'hFFF, 8'h00);
        do_req(0, 12'h800, 8'h00);
        do_req(0, 12'h0FF, 8'h00);
        wait_idle();
        // R1: valid held high across a busy period
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h444; req_wdata = 8'h77;
        repeat (30) @(negedge clk);
        req_valid = 0;
        wait_idle();
        do_req(0, 12'h444, 8'h00);
        // mixed traffic
        for (int i = 0; i < 24; i++) begin
            bit [11:0] ad;
            ad = 12'((i * 613) % 4096);
            do_req((i % 3) != 0, ad, 8'(i * 29 + 1));
            if (i % 5 == 0) wait_idle();
        end
        wait_idle();
        finish_run();
    end

endmodule